// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block gathers the data bytes of one write transaction into a small page latch and commits them to a 256-entry byte store only when the transaction ends with a stop event. A transaction opens with a word-address load. Each following byte strobe fills the latch slot picked by the low address bits. Only those low bits then advance, so the page base never moves and a long burst wraps around and overwrites its own earlier bytes. Each slot keeps a written flag. The commit copies only flagged slots, so the other locations of the page keep their old contents.

After the commit the block raises `busy` for a fixed number of clock cycles. This stands in for the self-timed programming time of a nonvolatile array. The surrounding bus front end uses `busy` to withhold every acknowledge, including the address acknowledge. While busy, the block ignores address loads, byte strobes and stops. The word-address counter is shared with the read path and is visible on `word_addr`. After a commit it holds the address of the last byte written, so a following current-address read can continue from the next location. A separate combinational read port gives access to the store.

The control is a five-state machine:
- `ST_IDLE` has no address loaded.
- `ST_ADDR` has an address but no data byte yet.
- `ST_COLLECT` holds at least one latched byte.
- `ST_COMMIT` visits one page slot per cycle and writes the flagged ones.
- `ST_BUSY` waits for the cycle timer to expire.

The transitions are:
- IDLE→ADDR on an address load.
- ADDR→ADDR on a reload.
- ADDR→COLLECT on a byte.
- ADDR→IDLE on a stop.
- COLLECT→ADDR on a reload.
- COLLECT→COMMIT on a stop.
- COMMIT→BUSY after the last slot.
- COMMIT→IDLE instead, if the timer has already expired at the last slot.
- BUSY→IDLE when the timer expires.

When several strobes arrive in one cycle, stop beats address load, and address load beats byte strobe.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, `busy` is 0, `word_addr` is 0 and every storage location reads 0.
- R2: An address load accepted while not busy sets `word_addr` to `addr_in` and discards bytes already latched in that transaction. A discarded location keeps its previous content after the stop.
- R3: Each accepted byte goes to the page slot given by `word_addr[1:0]`. After it, `word_addr[1:0]` increments modulo 4 and `word_addr[7:2]` is unchanged.
- R4: When more than four bytes arrive before the stop, a later byte that lands on an already written slot replaces the earlier value, and only the last value is committed.
- R5: No storage location changes before the stop that ends the transaction. The store is written only while `busy` is 1.
- R6: A stop received after at least one data byte makes `busy` rise on the next clock edge. `busy` stays 1 for exactly `WR_CYCLES` cycles, and afterwards the store holds the latched bytes.
- R7: Only slots written in the transaction are committed. The other three locations of the page keep their old contents.
- R8: A stop that follows an address load with no data byte does not raise `busy` and changes no storage location.
- R9: While `busy` is 1, address loads, byte strobes and stops are ignored. `word_addr` does not change and none of those bytes reach the store.
- R10: After a commit, `word_addr` holds the address of the last byte written: the page base with the low two bits of the final slot used.
- R11: A byte strobe with no address loaded since reset or since the last stop is ignored. `word_addr` is unchanged and a following stop raises no `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | One-cycle strobe: load `addr_in` as word address |
| addr_in | input | 8 | Word address from the bus front end |
| byte_stb | input | 1 | One-cycle strobe: a data byte was received |
| byte_in | input | 8 | Received data byte |
| stop_evt | input | 1 | One-cycle strobe: stop condition seen |
| rd_addr | input | 8 | Storage read address |
| busy | output | 1 | Write cycle in progress; bus responses must be withheld |
| word_addr | output | 8 | Shared word-address counter |
| rd_data | output | 8 | Storage content at `rd_addr` (combinational) |

## Verification
The bench tries several input patterns, and each tells apart a different kind of wrong commit:
- A single byte write.
- A four-byte page that starts mid-page, so the low bits wrap.
- A six-byte burst that overwrites two of its own slots.
- A two-byte partial page on top of earlier data, which separates slot-flagged commits from whole-page commits.
- An address-only transaction and orphan bytes with no address, which separate "stop with data" from "any stop".
- Strobes issued inside the busy window, which show whether the window really blocks input.
- An address reload in mid-transaction, which shows whether stale latched bytes are discarded.

The busy length and the resulting `word_addr` are measured after each commit.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_COLLECT = 3'd2,
        ST_COMMIT  = 3'd3,
        ST_BUSY    = 3'd4
    } pcb_state_e;
endpackage

// File: rtl/pcb_page_latch.sv
// Page latch: one data register and one written flag per slot.
module pcb_page_latch #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 4,
    localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clear,
    input  logic                               wr_en,
    input  logic [SLOT_W-1:0]                  wr_slot,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]  slot_data,
    output logic [PAGE_BYTES-1:0]              slot_valid
);
    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_slot == SLOT_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_data[s]  <= '0;
                slot_valid[s] <= 1'b0;
            end else if (clear) begin
                slot_valid[s] <= 1'b0;
            end else if (hit) begin
                slot_data[s]  <= wr_data;
                slot_valid[s] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcb_timer.sv
// Down-counter standing in for the self-timed programming interval.
module pcb_timer #(
    parameter int WR_CYCLES = 40,
    localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(WR_CYCLES - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pcb_store.sv
// Byte store with one write port and one combinational read port.
module pcb_store #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/page_commit_buffer.sv
// Collects one write transaction in a page latch, commits flagged slots at
// stop, then holds busy for WR_CYCLES clocks.
// WR_CYCLES must be at least PAGE_BYTES; PAGE_BYTES a power of two >= 2.
module page_commit_buffer
    import pcb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 4,
    parameter int WR_CYCLES  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              stop_evt,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic [ADDR_W-1:0] word_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - SLOT_W;

    pcb_state_e state_q, state_d;

    logic [ADDR_W-1:0]              ptr_q;
    logic [SLOT_W-1:0]              commit_idx_q;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] slot_data;
    logic [PAGE_BYTES-1:0]          slot_valid;
    logic                           timer_done;
    logic                           last_slot;

    logic acc_addr, acc_byte, go_commit, timer_run, mem_we;

    logic [SLOT_W-1:0] ptr_lo;
    logic [PAGE_W-1:0] ptr_hi;
    assign ptr_lo    = ptr_q[SLOT_W-1:0];
    assign ptr_hi    = ptr_q[ADDR_W-1:SLOT_W];
    assign last_slot = (commit_idx_q == SLOT_W'(PAGE_BYTES - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic; priority stop > address load > byte strobe
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!stop_evt && addr_load) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (stop_evt)       state_d = ST_IDLE;
                else if (addr_load) state_d = ST_ADDR;
                else if (byte_stb)  state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (stop_evt)       state_d = ST_COMMIT;
                else if (addr_load) state_d = ST_ADDR;
            end
            ST_COMMIT: begin
                if (last_slot) state_d = timer_done ? ST_IDLE : ST_BUSY;
            end
            ST_BUSY: begin
                if (timer_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output / control decode
    always_comb begin
        acc_addr  = 1'b0;
        acc_byte  = 1'b0;
        go_commit = 1'b0;
        timer_run = 1'b0;
        mem_we    = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                acc_addr = addr_load && !stop_evt;
            end
            ST_ADDR, ST_COLLECT: begin
                acc_addr  = addr_load && !stop_evt;
                acc_byte  = byte_stb && !addr_load && !stop_evt;
                go_commit = stop_evt && (state_q == ST_COLLECT);
            end
            ST_COMMIT: begin
                busy      = 1'b1;
                timer_run = 1'b1;
                mem_we    = slot_valid[commit_idx_q];
            end
            ST_BUSY: begin
                busy      = 1'b1;
                timer_run = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // Shared word-address counter: page base fixed, low bits wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (acc_addr) begin
            ptr_q <= addr_in;
        end else if (acc_byte) begin
            ptr_q <= {ptr_hi, ptr_lo + 1'b1};
        end else if (go_commit) begin
            ptr_q <= {ptr_hi, ptr_lo - 1'b1};
        end
    end

    // Commit slot walker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_idx_q <= '0;
        end else if (go_commit) begin
            commit_idx_q <= '0;
        end else if (state_q == ST_COMMIT) begin
            commit_idx_q <= commit_idx_q + 1'b1;
        end
    end

    assign word_addr = ptr_q;

    pcb_page_latch #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (acc_addr),
        .wr_en      (acc_byte),
        .wr_slot    (ptr_lo),
        .wr_data    (byte_in),
        .slot_data  (slot_data),
        .slot_valid (slot_valid)
    );

    pcb_timer #(
        .WR_CYCLES (WR_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go_commit),
        .run   (timer_run),
        .done  (timer_done)
    );

    pcb_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr ({ptr_hi, commit_idx_q}),
        .wdata (slot_data[commit_idx_q]),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
    import pcb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SLOT_W    = 2,
    parameter int WR_CYCLES = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_load,
    input logic [ADDR_W-1:0] addr_in,
    input logic              byte_stb,
    input logic              stop_evt,
    input logic              busy,
    input logic [ADDR_W-1:0] word_addr,
    input pcb_state_e        state,
    input logic              mem_we
);
    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else busy_len <= 0;
    end

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load && !stop_evt && !busy) |=> (word_addr == $past(addr_in))); // R2

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !addr_load && !stop_evt && (state == ST_ADDR || state == ST_COLLECT))
        |=> ((word_addr[ADDR_W-1:SLOT_W] == $past(word_addr[ADDR_W-1:SLOT_W])) &&
             (word_addr[SLOT_W-1:0] == SLOT_W'($past(word_addr[SLOT_W-1:0]) + 1'b1)))); // R3

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R5

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt)); // R6

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == WR_CYCLES)); // R6

    AST_NO_WRITE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && state == ST_ADDR) |=> !busy); // R8

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(word_addr)); // R9
endmodule

bind page_commit_buffer pcb_checker #(
    .ADDR_W    (ADDR_W),
    .SLOT_W    (SLOT_W),
    .WR_CYCLES (WR_CYCLES)
) u_pcb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_load (addr_load),
    .addr_in   (addr_in),
    .byte_stb  (byte_stb),
    .stop_evt  (stop_evt),
    .busy      (busy),
    .word_addr (word_addr),
    .state     (state_q),
    .mem_we    (mem_we)
);

// File: tb/page_commit_buffer_tb.sv
module page_commit_buffer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int WR = 12;

    logic clk, rst_n, addr_load, byte_stb, stop_evt;
    logic [AW-1:0] addr_in, rd_addr, word_addr;
    logic [DW-1:0] byte_in, rd_data;
    logic busy;

    page_commit_buffer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(4), .WR_CYCLES(WR)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .stop_evt(stop_evt),
        .rd_addr(rd_addr), .busy(busy), .word_addr(word_addr), .rd_data(rd_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";

    task automatic chk(input string req, input logic [31:0] act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Behavioural reference model, updated on every rising edge
    int m_mem [256];
    int m_slot [4];
    bit m_val [4];
    int m_ptr;
    bit m_has;
    int m_cnt;
    bit m_any;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_mem[i] = 0;
            for (int k = 0; k < 4; k++) begin m_slot[k] = 0; m_val[k] = 0; end
            m_ptr = 0; m_has = 0; m_cnt = 0;
        end else if (m_cnt > 0) begin
            m_cnt--;
        end else if (stop_evt) begin
            m_any = 0;
            for (int k = 0; k < 4; k++) if (m_val[k]) m_any = 1;
            if (m_has && m_any) begin
                for (int k = 0; k < 4; k++)
                    if (m_val[k]) m_mem[(m_ptr & 'hFC) + k] = m_slot[k];
                m_ptr = (m_ptr & 'hFC) | ((m_ptr - 1) & 3);
                m_cnt = WR;
            end
            m_has = 0;
        end else if (addr_load) begin
            m_ptr = addr_in;
            m_has = 1;
            for (int k = 0; k < 4; k++) m_val[k] = 0;
        end else if (byte_stb && m_has) begin
            m_slot[m_ptr & 3] = byte_in;
            m_val[m_ptr & 3]  = 1;
            m_ptr = (m_ptr & 'hFC) | ((m_ptr + 1) & 3);
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk({phase, " model busy"}, busy, (m_cnt > 0) ? 1 : 0);
            chk({phase, " model word_addr"}, word_addr, m_ptr);
            if (m_cnt == 0) chk({phase, " model rd_data"}, rd_data, m_mem[rd_addr]);
        end
    end

    task automatic do_addr(input int a);
        @(negedge clk); addr_load = 1'b1; addr_in = a[AW-1:0];
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic do_byte(input int b);
        @(negedge clk); byte_stb = 1'b1; byte_in = b[DW-1:0];
        @(negedge clk); byte_stb = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        #2;
        while (busy && n < 10 * WR) begin
            n++;
            @(negedge clk); #2;
        end
    endtask

    task automatic wait_idle();
        @(negedge clk); #2;
        while (busy) begin @(negedge clk); #2; end
    endtask

    task automatic read_chk(input int a, input int exp, input string req);
        @(negedge clk); rd_addr = a[AW-1:0]; #2;
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int n;
        rst_n = 1'b0; addr_load = 1'b0; byte_stb = 1'b0; stop_evt = 1'b0;
        addr_in = '0; byte_in = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        #2;
        chk("R1 busy", busy, 0);
        chk("R1 word_addr", word_addr, 0);
        rst_n = 1'b1;
        read_chk('h10, 0, "R1 mem");
        read_chk('hFF, 0, "R1 mem");

        // R11: orphan byte and stop
        phase = "R11";
        do_byte('h77);
        #2 chk("R11 word_addr", word_addr, 0);
        do_stop();
        #2 chk("R11 busy", busy, 0);
        read_chk('h00, 0, "R11 mem");

        // Single byte write: R2, R3, R5, R6, R10, R7
        phase = "R6";
        do_addr('h10);
        #2 chk("R2 word_addr", word_addr, 'h10);
        do_byte('hA5);
        #2 chk("R3 word_addr", word_addr, 'h11);
        read_chk('h10, 0, "R5 before stop");
        do_stop();
        measure_busy(n);
        chk("R6 busy length", n, WR);
        chk("R10 word_addr", word_addr, 'h10);
        read_chk('h10, 'hA5, "R6 committed");
        read_chk('h11, 0, "R7 untouched");

        // Four bytes from mid-page: wrap
        phase = "R3";
        do_addr('h22);
        do_byte('h31);
        do_byte('h32);
        #2 chk("R3 wrap word_addr", word_addr, 'h20);
        do_byte('h33);
        do_byte('h34);
        do_stop();
        measure_busy(n);
        chk("R6 busy length", n, WR);
        chk("R10 word_addr", word_addr, 'h21);
        read_chk('h22, 'h31, "R3 slot");
        read_chk('h23, 'h32, "R3 slot");
        read_chk('h20, 'h33, "R3 slot");
        read_chk('h21, 'h34, "R3 slot");

        // Six bytes: overwrite
        phase = "R4";
        do_addr('h40);
        for (int i = 0; i < 6; i++) do_byte('h51 + i);
        read_chk('h40, 0, "R5 before stop");
        do_stop();
        wait_idle();
        chk("R10 word_addr", word_addr, 'h41);
        read_chk('h40, 'h55, "R4 overwrite");
        read_chk('h41, 'h56, "R4 overwrite");
        read_chk('h42, 'h53, "R4 kept");
        read_chk('h43, 'h54, "R4 kept");

        // Partial page over earlier data
        phase = "R7";
        do_addr('h21);
        do_byte('h61);
        do_byte('h62);
        do_stop();
        wait_idle();
        read_chk('h21, 'h61, "R7 written");
        read_chk('h22, 'h62, "R7 written");
        read_chk('h20, 'h33, "R7 old kept");
        read_chk('h23, 'h32, "R7 old kept");

        // Address-only transaction
        phase = "R8";
        do_addr('h60);
        do_stop();
        for (int i = 0; i < 3; i++) begin
            #2 chk("R8 busy", busy, 0);
            @(negedge clk);
        end
        chk("R8 word_addr", word_addr, 'h60);
        read_chk('h60, 0, "R8 mem");

        // Strobes while busy
        phase = "R9";
        do_addr('h70);
        do_byte('h81);
        do_stop();
        do_addr('h80);
        do_byte('h90);
        do_stop();
        #2 chk("R9 busy", busy, 1);
        chk("R9 word_addr", word_addr, 'h70);
        wait_idle();
        read_chk('h80, 0, "R9 ignored");
        read_chk('h70, 'h81, "R9 commit");
        phase = "R11";
        do_byte('h99);
        #2 chk("R11 word_addr", word_addr, 'h70);
        do_stop();
        #2 chk("R11 busy", busy, 0);

        // Reload discards latched bytes
        phase = "R2";
        do_addr('h30);
        do_byte('h11);
        do_addr('h34);
        #2 chk("R2 reload", word_addr, 'h34);
        do_byte('h22);
        do_stop();
        wait_idle();
        read_chk('h30, 0, "R2 discarded");
        read_chk('h34, 'h22, "R2 new");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule